// File: doc/BRIEF.md
# CAN Bit-Level Protocol Error Detector

This block watches the bit stream of one CAN node, one sampled bit at a time, and reports the five protocol error classes: bit, stuff, form, acknowledge and CRC. For each bit the frame controller supplies four things:
- a sample strobe,
- the level read from the bus,
- the level the node drove,
- a flag saying whether the node is the transmitter of the current frame.

It also supplies one-hot-style markers for the field the bit belongs to: arbitration, CRC sequence, CRC delimiter, ACK slot, ACK delimiter, end of frame and interframe space. A sample flagged as start of frame opens a new frame.

Internally the block tracks bit-stuffing runs. It tells the frame controller which samples are stuff bits, so that those samples are not taken as data. It runs a 15-bit CRC over the de-stuffed bits and captures the received CRC sequence so that the two can be compared.

Any detected error produces one type pulse and a request for an error frame. When the node is the transmitter, it also produces a retransmission mark. After the first error, all further checks stay silent until the next start of frame.

The sample input is a plain strobe. The block accepts a sample on every clock in which `smp_vld` is high and never applies back-pressure, so no ready signal exists. All outputs are registered and appear exactly one clock after the sample they describe, as single-cycle pulses.

Top module: `can_bit_err_det`

## Requirements
- R1: The CRC uses polynomial 0x4599 and starts from zero. It covers every non-stuff bit from the start-of-frame sample up to, but not including, the first CRC-sequence sample. Received CRC-sequence bits (non-stuff, MSB first) are collected. On the CRC-delimiter sample, a mismatch between the computed and received values pulses `err_crc`.
- R2: When `node_is_tx` is high and a recessive (1) level is read in the ACK slot, `err_ack` pulses.
- R3: A dominant (0) level read during the CRC delimiter, ACK delimiter, end of frame or interframe space pulses `err_form`.
- R4: When `node_is_tx` is high and the read level differs from the driven level, `err_bit` pulses, except in the case covered by R5.
- R5: Driving recessive and reading dominant while `f_arb` or `f_ack_slot` is high is not a bit error. The same pair outside those fields is a bit error.
- R6: The stuffing zone runs from the start-of-frame sample up to the CRC delimiter, with the delimiter excluded. Within that zone, a sixth consecutive bit of equal level pulses `err_stuff`.
- R7: Every error pulse is accompanied in the same cycle by `err_frame_req`. `retx_mark` pulses together with it when `node_is_tx` was high for that sample.
- R8: At most one type pulse is issued per sample, with priority bit > stuff > form > ack > crc.
- R9: After five equal bits in the stuffing zone, the next bit of opposite level is flagged on `stuff_flag`. That bit is kept out of the CRC and of the received CRC sequence, and it starts a new run of length one.
- R10: Once an error is reported, no further error pulse is produced until the next start-of-frame sample. That start-of-frame sample is itself checked.
- R11: During and right after reset, all outputs are low.
- R12: Every output is a registered pulse. It is high only in the clock that follows an accepted sample, and it is low after a clock with `smp_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | One bit sample is presented this cycle |
| smp_sof | input | 1 | This sample is the start-of-frame bit |
| smp_rx | input | 1 | Level read from the bus (0 dominant) |
| smp_tx | input | 1 | Level the node drove for this bit |
| node_is_tx | input | 1 | Node is transmitter of the current frame |
| f_arb | input | 1 | Sample lies in the arbitration field |
| f_crc_seq | input | 1 | Sample lies in the CRC sequence |
| f_crc_dlm | input | 1 | Sample is the CRC delimiter |
| f_ack_slot | input | 1 | Sample is the ACK slot |
| f_ack_dlm | input | 1 | Sample is the ACK delimiter |
| f_eof | input | 1 | Sample lies in end of frame |
| f_ifs | input | 1 | Sample lies in interframe space |
| stuff_flag | output | 1 | Previous sample was a stuff bit |
| err_bit | output | 1 | Bit error pulse |
| err_stuff | output | 1 | Stuff error pulse |
| err_form | output | 1 | Form error pulse |
| err_ack | output | 1 | Acknowledge error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_frame_req | output | 1 | Error frame request |
| retx_mark | output | 1 | Frame must be repeated by this transmitter |

## Verification
A table of single samples drives short hand-built sequences. These separate the arbitration and ACK-slot exemption from a real bit error, a legal five-bit run plus stuff bit from a six-bit run, and dominant levels inside fixed-form fields from recessive ones. The table also covers masking after a first error and the priority when a bit error and a stuff error fall on the same bit.

Complete frames are then built with stuffing and CRC computed by the bench:
- an all-zero payload, which is heavy in stuff bits;
- a frame with one CRC bit flipped;
- transmitter frames with and without an acknowledge.

These frames tell apart correct de-stuffing and CRC accumulation from an off-by-one in the stuff run or in the CRC span.

// File: rtl/can_err_pkg.sv
`timescale 1ns/1ps
package can_err_pkg;
  localparam int unsigned ERR_N   = 5;
  // error vector positions, lowest index wins (R8)
  localparam int unsigned IX_BIT   = 0;
  localparam int unsigned IX_STUFF = 1;
  localparam int unsigned IX_FORM  = 2;
  localparam int unsigned IX_ACK   = 3;
  localparam int unsigned IX_CRC   = 4;
  typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/can_stuff_track.sv
`timescale 1ns/1ps
module can_stuff_track #(
  parameter int unsigned RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic sof,
  input  logic zone,
  input  logic rx,
  output logic is_stuff,
  output logic viol
);
  localparam int unsigned CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          last_q;
  logic          due;
  logic          active;

  assign due    = (cnt_q == CW'(RUN));
  assign active = vld & zone & ~sof;

  always_comb begin
    is_stuff = active & due & (rx != last_q);
    viol     = active & due & (rx == last_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (vld && zone) begin
      if (sof) begin
        cnt_q  <= CW'(1);
        last_q <= rx;
      end else if (due) begin
        if (rx != last_q) begin
          cnt_q  <= CW'(1);
          last_q <= rx;
        end
      end else if (rx == last_q) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q  <= CW'(1);
        last_q <= rx;
      end
    end
  end
endmodule

// File: rtl/can_crc_acc.sv
`timescale 1ns/1ps
module can_crc_acc #(
  parameter int unsigned       W    = 15,
  parameter logic [W-1:0]      POLY = W'(16'h4599)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;

  function automatic logic [W-1:0] advance(input logic [W-1:0] base, input logic b);
    logic fb;
    fb = b ^ base[W-1];
    return {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= '0;
    else if (start) crc_q <= advance('0, din);
    else if (step)  crc_q <= advance(crc_q, din);
  end

  assign crc = crc_q;
endmodule

// File: rtl/can_err_classify.sv
`timescale 1ns/1ps
module can_err_classify
  import can_err_pkg::*;
(
  input  logic     node_tx,
  input  logic     rx,
  input  logic     tx,
  input  logic     arb,
  input  logic     ack_slot,
  input  logic     crc_dlm,
  input  logic     ack_dlm,
  input  logic     eof,
  input  logic     ifs,
  input  logic     stuff_viol,
  input  logic     crc_bad,
  output err_vec_t vec
);
  err_vec_t raw;
  logic     exempt;

  always_comb begin
    exempt          = tx & ~rx & (arb | ack_slot);
    raw             = '0;
    raw[IX_BIT]     = node_tx & (rx != tx) & ~exempt;
    raw[IX_STUFF]   = stuff_viol;
    raw[IX_FORM]    = ~rx & (crc_dlm | ack_dlm | eof | ifs);
    raw[IX_ACK]     = node_tx & ack_slot & rx;
    raw[IX_CRC]     = crc_bad;
  end

  // priority pick: lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    vec   = '0;
    for (int i = 0; i < int'(ERR_N); i++) begin
      if (raw[i] && !taken) begin
        vec[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_bit_err_det.sv
`timescale 1ns/1ps
module can_bit_err_det
  import can_err_pkg::*;
#(
  parameter int unsigned          CRC_W     = 15,
  parameter logic [CRC_W-1:0]     CRC_POLY  = CRC_W'(16'h4599),
  parameter int unsigned          STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic smp_sof,
  input  logic smp_rx,
  input  logic smp_tx,
  input  logic node_is_tx,
  input  logic f_arb,
  input  logic f_crc_seq,
  input  logic f_crc_dlm,
  input  logic f_ack_slot,
  input  logic f_ack_dlm,
  input  logic f_eof,
  input  logic f_ifs,
  output logic stuff_flag,
  output logic err_bit,
  output logic err_stuff,
  output logic err_form,
  output logic err_ack,
  output logic err_crc,
  output logic err_frame_req,
  output logic retx_mark
);
  logic             zone_q, zone_now;
  logic             crcph_q, crc_now;
  logic             is_stuff, stuff_viol;
  logic [CRC_W-1:0] crc_calc, rcv_q;
  logic             crc_bad;
  logic             mask_q, mask_now;
  err_vec_t         vec, errs, err_q;
  logic             stf_q, req_q, retx_q;

  // stuffing zone: SOF up to (not incl.) CRC delimiter
  assign zone_now = smp_sof | (zone_q & ~f_crc_dlm);
  // CRC span: SOF up to first CRC-sequence sample
  assign crc_now  = (smp_sof | crcph_q) & ~f_crc_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zone_q  <= 1'b0;
      crcph_q <= 1'b0;
    end else if (smp_vld) begin
      zone_q  <= zone_now;
      crcph_q <= crc_now;
    end
  end

  can_stuff_track #(.RUN(STUFF_RUN)) u_stuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (smp_vld),
    .sof      (smp_sof),
    .zone     (zone_now),
    .rx       (smp_rx),
    .is_stuff (is_stuff),
    .viol     (stuff_viol)
  );

  can_crc_acc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (smp_vld & smp_sof),
    .step  (smp_vld & crc_now & ~is_stuff & ~smp_sof),
    .din   (smp_rx),
    .crc   (crc_calc)
  );

  // received CRC sequence, MSB first, stuff bits skipped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcv_q <= '0;
    end else if (smp_vld) begin
      if (smp_sof)
        rcv_q <= '0;
      else if (f_crc_seq && zone_now && !is_stuff)
        rcv_q <= {rcv_q[CRC_W-2:0], smp_rx};
    end
  end

  assign crc_bad = f_crc_dlm & (rcv_q != crc_calc);

  can_err_classify u_cls (
    .node_tx    (node_is_tx),
    .rx         (smp_rx),
    .tx         (smp_tx),
    .arb        (f_arb),
    .ack_slot   (f_ack_slot),
    .crc_dlm    (f_crc_dlm),
    .ack_dlm    (f_ack_dlm),
    .eof        (f_eof),
    .ifs        (f_ifs),
    .stuff_viol (stuff_viol),
    .crc_bad    (crc_bad),
    .vec        (vec)
  );

  assign mask_now = smp_sof ? 1'b0 : mask_q;
  assign errs     = (smp_vld && !mask_now) ? vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      err_q  <= '0;
      stf_q  <= 1'b0;
      req_q  <= 1'b0;
      retx_q <= 1'b0;
    end else begin
      if (smp_vld) mask_q <= mask_now | (|errs);
      err_q  <= errs;
      stf_q  <= smp_vld & is_stuff;
      req_q  <= |errs;
      retx_q <= (|errs) & node_is_tx;
    end
  end

  assign stuff_flag    = stf_q;
  assign err_bit       = err_q[IX_BIT];
  assign err_stuff     = err_q[IX_STUFF];
  assign err_form      = err_q[IX_FORM];
  assign err_ack       = err_q[IX_ACK];
  assign err_crc       = err_q[IX_CRC];
  assign err_frame_req = req_q;
  assign retx_mark     = retx_q;
endmodule

// File: rtl/can_bit_err_det_chk.sv
`timescale 1ns/1ps
module can_bit_err_det_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic smp_sof,
  input logic smp_rx,
  input logic smp_tx,
  input logic node_is_tx,
  input logic f_arb,
  input logic f_crc_seq,
  input logic f_crc_dlm,
  input logic f_ack_slot,
  input logic f_ack_dlm,
  input logic f_eof,
  input logic f_ifs,
  input logic stuff_flag,
  input logic err_bit,
  input logic err_stuff,
  input logic err_form,
  input logic err_ack,
  input logic err_crc,
  input logic err_frame_req,
  input logic retx_mark
);
  AST_ONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_bit, err_stuff, err_form, err_ack, err_crc})); // R8
  AST_ACK_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |-> $past(node_is_tx && f_ack_slot && smp_rx)); // R2
  AST_FORM_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    err_form |-> $past(!smp_rx && (f_crc_dlm || f_ack_dlm || f_eof || f_ifs))); // R3
  AST_BIT_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> $past(node_is_tx && (smp_rx != smp_tx))); // R4
  AST_ARB_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld && smp_tx && !smp_rx && (f_arb || f_ack_slot)) |-> !err_bit); // R5
  AST_CRC_AT_DLM: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> $past(f_crc_dlm)); // R1
  AST_REQ_WITH_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bit || err_stuff || err_form || err_ack || err_crc) |-> err_frame_req); // R7
  AST_RETX_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    retx_mark |-> (err_frame_req && $past(node_is_tx))); // R7
  AST_STUFF_NOT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_flag |-> $past(smp_vld && !smp_sof)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> !(err_frame_req || stuff_flag)); // R12
endmodule

bind can_bit_err_det can_bit_err_det_chk u_chk (.*);

// File: tb/can_bit_err_det_tb_top.sv
`timescale 1ns/1ps
module can_bit_err_det_tb_top;
  typedef struct packed {
    logic       sof, rx, tx, ntx, arb, crcs, cdlm, aslot, adlm, eof, ifs;
    logic [4:0] exp;   // [0] bit [1] stuff [2] form [3] ack [4] crc
    logic       stf;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{1,0,0,1,1,0,0,0,0,0,0,5'b00000,0}, // 0 sof tx
    '{0,0,1,1,1,0,0,0,0,0,0,5'b00000,0}, // 1 R5 arb exempt
    '{0,1,0,1,1,0,0,0,0,0,0,5'b00001,0}, // 2 R4 dom sent rec read
    '{0,1,0,1,0,0,0,0,0,0,0,5'b00000,0}, // 3 R10 masked
    '{1,0,0,0,0,0,0,0,0,0,0,5'b00000,0}, // 4 sof rx
    '{0,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,0,0,0,0,0,5'b00000,0}, // 8 five equal
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00000,1}, // 9 R9 stuff bit
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,0,0,0,5'b00010,0}, // 14 R6 sixth equal
    '{1,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,1,0,0,0,0,5'b00100,0}, // 16 R3 crc dlm dominant
    '{1,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,0,0,0,1,0,5'b00100,0}, // 18 R3 eof dominant
    '{1,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,0,0,0,0,0,0,0,1,5'b00100,0}, // 20 R3 ifs dominant
    '{1,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,1,1,0,0,0,1,0,0,0,5'b00000,0}, // 22 R5 ack slot exempt
    '{0,1,1,1,0,0,0,1,0,0,0,5'b01000,0}, // 23 R2 no ack
    '{1,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,1,1,0,0,0,0,0,0,0,5'b00001,0}, // 25 R5 outside exempt field
    '{1,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,0,1,0,0,0,0,0,0,0,5'b00000,0},
    '{0,0,1,1,0,0,0,0,0,0,0,5'b00001,0}, // 31 R8 bit beats stuff
    '{1,0,0,0,0,0,0,0,0,0,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,1,0,0,5'b00000,0}, // 33 R3 recessive ack dlm ok
    '{0,1,1,0,0,0,0,0,0,1,0,5'b00000,0},
    '{0,1,1,0,0,0,0,0,0,0,1,5'b00000,0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 0, smp_sof = 0, smp_rx = 1, smp_tx = 1, node_is_tx = 0;
  logic f_arb = 0, f_crc_seq = 0, f_crc_dlm = 0, f_ack_slot = 0, f_ack_dlm = 0, f_eof = 0, f_ifs = 0;
  logic stuff_flag, err_bit, err_stuff, err_form, err_ack, err_crc, err_frame_req, retx_mark;

  int n_chk = 0, n_err = 0;
  logic [4:0] got_err;
  logic got_stf, got_req, got_retx;
  logic done = 0;
  // frame stream state
  int   run_cnt, stf_exp, stf_got;
  logic run_last;
  logic [4:0] frm_or;

  always #5 clk = ~clk;

  can_bit_err_det dut_i (.*);

  task automatic check(input bit ok, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  task automatic smp(input vec_t v);
    @(negedge clk);
    smp_vld = 1; smp_sof = v.sof; smp_rx = v.rx; smp_tx = v.tx; node_is_tx = v.ntx;
    f_arb = v.arb; f_crc_seq = v.crcs; f_crc_dlm = v.cdlm; f_ack_slot = v.aslot;
    f_ack_dlm = v.adlm; f_eof = v.eof; f_ifs = v.ifs;
    @(negedge clk);
    smp_vld = 0; smp_sof = 0;
    got_err  = {err_crc, err_ack, err_form, err_stuff, err_bit};
    got_stf  = stuff_flag;
    got_req  = err_frame_req;
    got_retx = retx_mark;
  endtask

  function automatic logic [14:0] cnext(input logic [14:0] c, input logic b);
    logic fb;
    fb = b ^ c[14];
    return {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
  endfunction

  function automatic vec_t mk(input logic sof, input logic b, input logic ntx, input logic txv,
                              input logic crcs, input logic cdlm, input logic aslot,
                              input logic adlm, input logic eof);
    vec_t v;
    v = '0;
    v.sof = sof; v.rx = b; v.tx = txv; v.ntx = ntx; v.crcs = crcs;
    v.cdlm = cdlm; v.aslot = aslot; v.adlm = adlm; v.eof = eof;
    return v;
  endfunction

  // send one frame-level bit, inserting a stuff bit first when due
  task automatic put(input vec_t v, input bit zone);
    vec_t s;
    if (zone && !v.sof && run_cnt == 5) begin
      s = v; s.rx = ~run_last; s.tx = ~run_last;
      stf_exp++;
      smp(s);
      frm_or |= got_err; stf_got += int'(got_stf);
      run_cnt = 1; run_last = ~run_last;
    end
    smp(v);
    frm_or |= got_err; stf_got += int'(got_stf);
    if (v.sof) begin run_cnt = 1; run_last = v.rx; end
    else if (zone) begin
      if (v.rx == run_last) run_cnt++;
      else begin run_cnt = 1; run_last = v.rx; end
    end
  endtask

  task automatic run_frame(input logic [15:0] pay, input bit flip, input logic ntx,
                           input bit ackd, input logic [4:0] exp, input string tag);
    logic [14:0] c;
    stf_exp = 0; stf_got = 0; frm_or = '0;
    c = cnext(15'h0, 1'b0);
    put(mk(1, 0, ntx, 0, 0, 0, 0, 0, 0), 1);
    for (int i = 15; i >= 0; i--) begin
      c = cnext(c, pay[i]);
      put(mk(0, pay[i], ntx, pay[i], 0, 0, 0, 0, 0), 1);
    end
    if (flip) c[0] = ~c[0];
    for (int i = 14; i >= 0; i--)
      put(mk(0, c[i], ntx, c[i], 1, 0, 0, 0, 0), 1);
    put(mk(0, 1, ntx, 1, 0, 1, 0, 0, 0), 0);
    put(mk(0, ackd ? 1'b0 : 1'b1, ntx, 1, 0, 0, 1, 0, 0), 0);
    put(mk(0, 1, ntx, 1, 0, 0, 0, 1, 0), 0);
    for (int i = 0; i < 7; i++) put(mk(0, 1, ntx, 1, 0, 0, 0, 0, 1), 0);
    check(frm_or == exp, {tag, " frame errors"}, frm_or, exp);
    check(stf_got == stf_exp, {tag, " R9 stuff count"}, stf_got, stf_exp);
  endtask

  function automatic string tag_of(input logic [4:0] e);
    if (e[0]) return "R4/R8 bit";
    if (e[1]) return "R6 stuff";
    if (e[2]) return "R3 form";
    if (e[3]) return "R2 ack";
    if (e[4]) return "R1 crc";
    return "R5/R10 none";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({stuff_flag, err_bit, err_stuff, err_form, err_ack, err_crc, err_frame_req, retx_mark} == 8'h0,
          "R11 outputs in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({stuff_flag, err_frame_req, retx_mark} == 3'b0, "R11 outputs after reset", 0, 0);

    for (int k = 0; k < NV; k++) begin
      smp(TBL[k]);
      check(got_err == TBL[k].exp, $sformatf("vec %0d %s", k, tag_of(TBL[k].exp)), got_err, TBL[k].exp);
      check(got_stf == TBL[k].stf, $sformatf("vec %0d R9 stuff flag", k), got_stf, TBL[k].stf);
      check(got_req == (|TBL[k].exp), $sformatf("vec %0d R7 request", k), got_req, |TBL[k].exp);
      check(got_retx == (TBL[k].ntx & (|TBL[k].exp)), $sformatf("vec %0d R7 retx", k),
            got_retx, TBL[k].ntx & (|TBL[k].exp));
    end

    // R12: idle cycle after a sample leaves outputs low
    @(negedge clk);
    check({err_frame_req, stuff_flag} == 2'b0, "R12 idle quiet", {err_frame_req, stuff_flag}, 0);

    run_frame(16'h0000, 0, 0, 1, 5'b00000, "R1 R9 zero payload");
    run_frame(16'hF83E, 1, 0, 1, 5'b10000, "R1 crc flip");
    run_frame(16'hF83E, 0, 0, 1, 5'b00000, "R1 good crc");
    run_frame(16'h5A3C, 0, 1, 1, 5'b00000, "R2 R5 tx acked");
    run_frame(16'h5A3C, 0, 1, 0, 5'b01000, "R2 tx no ack");
    check(got_retx == 1'b0, "R7 retx idle at frame end", got_retx, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule